// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the reservation monitor for one core that uses load-linked and store-conditional synchronization. A load-exclusive request makes a reservation by recording its physical address. A later store-exclusive is granted only when that reservation is still live and falls on the same cache line. When the store is granted, the block raises a strobe that forwards it to memory. A store marked as a swap is always granted. It does not look at the reservation and does not change it.

Coherence traffic can break a reservation. An invalidating snoop to the reserved line clears it, sets a sticky event bit and sends the core a one-cycle wakeup pulse. A local snoop-hit pulse clears the reservation and sets the event bit whatever the address. The event bit models the mailbox that wait-for-event consumes, and it stays set until the core pulses a clear input. Addresses are compared at cache-line granularity, and the line size is a parameter.

Within one clock edge the block applies events in a fixed order: snoops and local hits first, then the store-exclusive check, then a new load-exclusive reservation. All outputs are registered and update on the edge that follows the request.

Top module: `resv_monitor`

## Requirements
- R1: A load-exclusive (`ldx_valid_i`=1) stores the full `ldx_addr_i` into the reserved address and sets the reservation flag. Both are visible on `resv_addr_o`/`resv_valid_o` after the next clock edge.
- R2: A snoop that arrives while the reservation flag is clear changes nothing. The flag stays clear, the reserved address holds, and neither `evt_flag_o` nor `wake_o` is raised by it.
- R3: Two addresses match when they are equal after the low log2(LINE_BYTES) bits are dropped. With the default of 64 bytes, that means bits [5:0] are ignored.
- R4: A snoop whose line matches the live reservation has three effects after the next edge: the flag is cleared, `evt_flag_o` is set and `wake_o` is high for exactly that one cycle.
- R5: A local snoop-hit pulse clears the flag and sets `evt_flag_o` for any address and any flag state. It does not raise `wake_o`.
- R6: A store-exclusive with `stx_swap_i`=1 gives `stx_done_o`=1, `stx_pass_o`=1 and `stx_fwd_o`=1 after the next edge. The reservation flag and address are left unchanged.
- R7: A non-swap store-exclusive fails when the flag is clear or its line differs from the reserved line. On failure it gives `stx_done_o`=1, `stx_pass_o`=0 and `stx_fwd_o`=0, and the flag is cleared.
- R8: A non-swap store-exclusive that matches a live reservation gives `stx_pass_o`=1 and `stx_fwd_o`=1 and clears the flag. A repeated store therefore fails.
- R9: `evt_flag_o` stays set until `evt_clr_i` is pulsed. If a set and `evt_clr_i` arrive in the same cycle, the set wins.
- R10: While `rst_ni` is low, the flag, reserved address, event bit, wakeup and all store status outputs are 0.
- R11: When a snoop match or a local hit arrives in the same cycle as a non-swap store-exclusive, the snoop is applied first, so the store fails.
- R12: A load-exclusive in the same cycle as a store or snoop is applied last. The store is judged against the old reservation, and the new reservation survives.
- R13: `stx_done_o`, `stx_pass_o` and `stx_fwd_o` are 0 in any cycle that follows a cycle with no store-exclusive request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ldx_valid_i | input | 1 | Load-exclusive request |
| ldx_addr_i | input | ADDR_W | Load-exclusive physical address |
| stx_valid_i | input | 1 | Store-exclusive request |
| stx_addr_i | input | ADDR_W | Store-exclusive address |
| stx_swap_i | input | 1 | Store is a swap, so the reservation check is skipped |
| snp_valid_i | input | 1 | Invalidating snoop |
| snp_addr_i | input | ADDR_W | Snoop address |
| snp_local_hit_i | input | 1 | Local snoop-hit pulse |
| evt_clr_i | input | 1 | Wait-for-event consumes the event bit |
| stx_done_o | output | 1 | Store-exclusive status valid |
| stx_pass_o | output | 1 | Store-exclusive succeeded |
| stx_fwd_o | output | 1 | Forward the store to memory |
| evt_flag_o | output | 1 | Sticky event mailbox bit |
| wake_o | output | 1 | One-cycle core wakeup pulse |
| resv_valid_o | output | 1 | Reservation flag |
| resv_addr_o | output | ADDR_W | Reserved address |

## Verification
The directed cases cover four risky orderings, each with a known wrong result:
- A snoop that lands in the same offset-differing line as the reservation: a design that compared full addresses would keep the reservation alive.
- A snoop that coincides with a store to the reserved line: a design that checked the store first would grant a store whose line was just lost.
- A load-exclusive that coincides with a store: a design that applied the load first would grant the store against the new reservation.
- An event clear that coincides with an event set: a design that let the clear win would lose the wakeup event.

Further directed checks cover the other corners. A swap sent with no reservation must still pass and leave the flag alone. A second store after a success must fail. A snoop while the flag is clear must raise no event. Random traffic draws addresses from a few lines with random offsets, so matches, near misses and collisions all occur often.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef struct packed {
    logic done;
    logic pass;
    logic fwd;
  } stx_rsp_t;
endpackage

// File: rtl/resv_line_match.sv
module resv_line_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFF_W;

  assign hit_o = ((a_i ^ b_i) & LINE_MASK) == '0;
endmodule

// File: rtl/resv_state.sv
module resv_state
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              stx_valid_i,
  input  logic              stx_swap_i,
  input  logic              stx_hit_i,
  input  logic              ldx_valid_i,
  input  logic [ADDR_W-1:0] ldx_addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output stx_rsp_t          rsp_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  stx_rsp_t          rsp_q, rsp_d;
  logic              flag_post_snp, stx_ok, stx_chk;

  always_comb begin
    // order: snoop kill, then store check, then new reservation
    flag_post_snp = valid_q & ~kill_i;
    stx_chk       = stx_valid_i & ~stx_swap_i;
    stx_ok        = stx_valid_i & (stx_swap_i | (flag_post_snp & stx_hit_i));
    valid_d       = ldx_valid_i | (flag_post_snp & ~stx_chk);
    addr_d        = ldx_valid_i ? ldx_addr_i : addr_q;
    rsp_d.done    = stx_valid_i;
    rsp_d.pass    = stx_ok;
    rsp_d.fwd     = stx_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      rsp_q   <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      rsp_q   <= rsp_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign rsp_o   = rsp_q;

  // R1
  ldx_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldx_valid_i |=> (valid_q && addr_q == $past(ldx_addr_i)));
  // R6
  swap_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_valid_i && stx_swap_i) |=> (rsp_q.pass && rsp_q.fwd));
  // R6
  swap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_valid_i && stx_swap_i && !kill_i && !ldx_valid_i) |=> (valid_q == $past(valid_q)));
  // R7
  stx_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_valid_i && !stx_swap_i && (!valid_q || !stx_hit_i)) |=> (rsp_q.done && !rsp_q.pass && !rsp_q.fwd));
  // R8
  stx_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_valid_i && !stx_swap_i && !ldx_valid_i) |=> !valid_q);
  // R11
  snp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && stx_valid_i && !stx_swap_i) |=> !rsp_q.pass);
  // R13
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_valid_i |=> (!rsp_q.done && !rsp_q.pass && !rsp_q.fwd));
endmodule

// File: rtl/resv_event_mbox.sv
module resv_event_mbox (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic wake_i,
  output logic evt_o,
  output logic wake_o
);
  logic evt_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      evt_q  <= set_i | (evt_q & ~clr_i);
      wake_q <= wake_i;
    end
  end

  assign evt_o  = evt_q;
  assign wake_o = wake_q;

  // R9
  evt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> evt_q);
  // R9
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !clr_i) |=> evt_q);
  // R9
  evt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !evt_q);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldx_valid_i,
  input  logic [ADDR_W-1:0] ldx_addr_i,
  input  logic              stx_valid_i,
  input  logic [ADDR_W-1:0] stx_addr_i,
  input  logic              stx_swap_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              snp_local_hit_i,
  input  logic              evt_clr_i,
  output logic              stx_done_o,
  output logic              stx_pass_o,
  output logic              stx_fwd_o,
  output logic              evt_flag_o,
  output logic              wake_o,
  output logic              resv_valid_o,
  output logic [ADDR_W-1:0] resv_addr_o
);
  localparam int OFF_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;

  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              snp_line_hit, stx_line_hit, snp_match, kill;
  stx_rsp_t          rsp;

  resv_line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_snp_cmp (
    .a_i(snp_addr_i), .b_i(resv_addr), .hit_o(snp_line_hit));

  resv_line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_stx_cmp (
    .a_i(stx_addr_i), .b_i(resv_addr), .hit_o(stx_line_hit));

  assign snp_match = snp_valid_i & resv_valid & snp_line_hit;
  assign kill      = snp_match | snp_local_hit_i;

  resv_state #(.ADDR_W(ADDR_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kill_i      (kill),
    .stx_valid_i (stx_valid_i),
    .stx_swap_i  (stx_swap_i),
    .stx_hit_i   (stx_line_hit),
    .ldx_valid_i (ldx_valid_i),
    .ldx_addr_i  (ldx_addr_i),
    .valid_o     (resv_valid),
    .addr_o      (resv_addr),
    .rsp_o       (rsp)
  );

  resv_event_mbox u_mbox (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (kill),
    .clr_i  (evt_clr_i),
    .wake_i (snp_match),
    .evt_o  (evt_flag_o),
    .wake_o (wake_o)
  );

  assign stx_done_o   = rsp.done;
  assign stx_pass_o   = rsp.pass;
  assign stx_fwd_o    = rsp.fwd;
  assign resv_valid_o = resv_valid;
  assign resv_addr_o  = resv_addr;

  // R2
  snp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !resv_valid && !ldx_valid_i && !snp_local_hit_i) |=>
      (!resv_valid_o && $stable(resv_addr_o) && !wake_o));
  // R4
  snp_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_match |=> (wake_o && evt_flag_o));
  // R4
  snp_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_match && !ldx_valid_i) |=> !resv_valid_o);
  // R5
  local_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_local_hit_i && !ldx_valid_i) |=> (!resv_valid_o && evt_flag_o));
  // R7
  fwd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_fwd_o == stx_pass_o);
endmodule

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ldx_v = 0, stx_v = 0, swap = 0, snp_v = 0, loc = 0, clr = 0;
  logic [AW-1:0] ldx_a = '0, stx_a = '0, snp_a = '0;
  logic          done_o, pass_o, fwd_o, evt_o, wake_o, rv_o;
  logic [AW-1:0] ra_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  logic          m_flag = 0, m_evt = 0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .LINE_BYTES(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ldx_valid_i(ldx_v), .ldx_addr_i(ldx_a),
    .stx_valid_i(stx_v), .stx_addr_i(stx_a), .stx_swap_i(swap),
    .snp_valid_i(snp_v), .snp_addr_i(snp_a), .snp_local_hit_i(loc),
    .evt_clr_i(clr),
    .stx_done_o(done_o), .stx_pass_o(pass_o), .stx_fwd_o(fwd_o),
    .evt_flag_o(evt_o), .wake_o(wake_o),
    .resv_valid_o(rv_o), .resv_addr_o(ra_o));

  function automatic logic same_line(logic [AW-1:0] a, logic [AW-1:0] b);
    return (a >> 6) == (b >> 6);
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    ldx_v = 0; stx_v = 0; swap = 0; snp_v = 0; loc = 0; clr = 0;
  endtask

  // apply current inputs for one edge and compare against the model
  task automatic step(string tag);
    logic hit, f1, ok, e_wake, e_evt, e_flag;
    logic [AW-1:0] e_addr;
    hit    = snp_v & m_flag & same_line(snp_a, m_addr);
    f1     = m_flag & ~(hit | loc);
    ok     = stx_v & (swap | (f1 & same_line(stx_a, m_addr)));
    e_flag = ldx_v ? 1'b1 : (f1 & ~(stx_v & ~swap));
    e_addr = ldx_v ? ldx_a : m_addr;
    e_evt  = hit | loc | (m_evt & ~clr);
    e_wake = hit;
    @(posedge clk);
    #2;
    chk(tag, "resv_valid", {31'd0, rv_o}, {31'd0, e_flag});
    chk(tag, "resv_addr", ra_o, e_addr);
    chk(tag, "evt_flag", {31'd0, evt_o}, {31'd0, e_evt});
    chk(tag, "wake", {31'd0, wake_o}, {31'd0, e_wake});
    chk(tag, "stx_done", {31'd0, done_o}, {31'd0, stx_v});
    chk(tag, "stx_pass", {31'd0, pass_o}, {31'd0, ok});
    chk(tag, "stx_fwd", {31'd0, fwd_o}, {31'd0, ok});
    m_flag = e_flag; m_addr = e_addr; m_evt = e_evt;
    idle_in();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] bases [4];
    void'($urandom(32'd20240601));
    bases[0] = 32'h0000_1000; bases[1] = 32'h0000_1040;
    bases[2] = 32'h8000_2000; bases[3] = 32'h0000_3FC0;

    // R10 reset
    #12;
    chk("R10", "resv_valid", {31'd0, rv_o}, 32'd0);
    chk("R10", "resv_addr", ra_o, 32'd0);
    chk("R10", "evt_flag", {31'd0, evt_o}, 32'd0);
    chk("R10", "wake", {31'd0, wake_o}, 32'd0);
    chk("R10", "stx_done", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 snoop with no reservation
    snp_v = 1; snp_a = 32'h0000_1000; step("R2");
    // R1 reservation
    ldx_v = 1; ldx_a = 32'h0000_1013; step("R1");
    // R3 different line: no effect
    snp_v = 1; snp_a = 32'h0000_1053; step("R3");
    // R3/R4 same line, different offset
    snp_v = 1; snp_a = 32'h0000_103F; step("R4");
    step("R4");
    // R9 clear
    clr = 1; step("R9");
    // R5 local hit, unrelated address
    ldx_v = 1; ldx_a = 32'h0000_2000; step("R1");
    loc = 1; snp_a = 32'hFFFF_0000; step("R5");
    // R6 swap without reservation
    stx_v = 1; swap = 1; stx_a = 32'h1234_5678; step("R6");
    // R13 idle response
    step("R13");
    // R8 success then repeated failure
    ldx_v = 1; ldx_a = 32'h0000_4008; step("R1");
    stx_v = 1; stx_a = 32'h0000_4030; step("R8");
    stx_v = 1; stx_a = 32'h0000_4030; step("R8");
    // R7 mismatched line
    ldx_v = 1; ldx_a = 32'h0000_4008; step("R1");
    stx_v = 1; stx_a = 32'h0000_4048; step("R7");
    // R6 swap keeps reservation
    ldx_v = 1; ldx_a = 32'h0000_5000; step("R1");
    stx_v = 1; swap = 1; stx_a = 32'h0000_9000; step("R6");
    // R9 set and clear together
    loc = 1; clr = 1; step("R9");
    // R11 snoop beats store
    ldx_v = 1; ldx_a = 32'h0000_6000; step("R1");
    snp_v = 1; snp_a = 32'h0000_6004; stx_v = 1; stx_a = 32'h0000_6008; step("R11");
    ldx_v = 1; ldx_a = 32'h0000_6000; step("R1");
    loc = 1; stx_v = 1; stx_a = 32'h0000_6000; step("R11");
    // R12 load-exclusive with store and snoop
    ldx_v = 1; ldx_a = 32'h0000_7000; stx_v = 1; stx_a = 32'h0000_7000; step("R12");
    ldx_v = 1; ldx_a = 32'h0000_7100; snp_v = 1; snp_a = 32'h0000_7000; step("R12");
    clr = 1; step("R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      ldx_v = ($urandom % 5) == 0;
      ldx_a = bases[$urandom % 4] | ($urandom % 64);
      stx_v = ($urandom % 4) == 0;
      swap  = ($urandom % 6) == 0;
      stx_a = bases[$urandom % 4] | ($urandom % 64);
      snp_v = ($urandom % 4) == 0;
      snp_a = bases[$urandom % 4] | ($urandom % 64);
      loc   = ($urandom % 12) == 0;
      clr   = ($urandom % 5) == 0;
      step("R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule